// File: doc/BRIEF.md
# External Bank Select and Bus Spacing Sequencer

This block sits between an internal access request port and the pins of an external memory bus master. Each accepted request address is decoded into one of four equal, programmable banks or into the unbanked region. The block then drives an active-low select for the bank, a read or write strobe and the bus address. Bank 0 starts at a fixed base address. The size of each bank is a power of two, given as its base-2 logarithm on an input.

The block spaces accesses on the bus by itself. When a new access follows the previous strobe cycle directly, it inserts one idle bus cycle for a read-to-write turnaround or for a change of region. After a strobe to a region set to asynchronous mode with a waitstate code of 2 or more, it appends one hold cycle. In that cycle the address and select stay driven with the strobes low. A hold cycle stands in for any idle cycle that would also be due. No strobe starts until the acknowledge input has been sampled high. The requester sees a single busy output, and a request is taken in any cycle where busy is low.

Top module: `ext_bank_sequencer`

## Requirements
- R1: During and right after reset, all bank selects are high, both strobes are low, the bus address is zero and busy is low.
- R2: A strobe to an address with BASE + n*2^L <= address < BASE + (n+1)*2^L (n = 0..3, L = size input, BASE = 0x0080_0000) drives bank_sel_n_o bit n low and the other select bits high.
- R3: A strobe to an address below BASE or at/above BASE + 4*2^L keeps all selects high while still driving the strobe and address.
- R4: In a cycle that is neither a strobe cycle nor a hold cycle, all selects are high, both strobes are low and the bus address is zero.
- R5: A strobe cycle asserts rd_strobe_o only for a read (req_write_i = 0) and wr_strobe_o only for a write (req_write_i = 1), drives the request address on bus_addr_o and has busy low; with ack high, a request taken while the bus is idle strobes in the very next cycle.
- R6: A write that directly follows a read strobe in the same region gets exactly one idle cycle before its strobe.
- R7: An access that directly follows a strobe in a different region (bank or unbanked) gets exactly one idle cycle, whatever the region modes.
- R8: Read after read, write after write and read after write in the same region strobe in consecutive cycles with no idle cycle.
- R9: After a strobe to a region whose async bit is 1 and whose 3-bit waitstate code is 3'b010..3'b111, one hold cycle follows: both strobes low, select and address unchanged, busy high.
- R10: No hold cycle follows a strobe to a region in synchronous mode, or in asynchronous mode with code 3'b000 or 3'b001.
- R11: An access queued behind a hold cycle strobes right after that hold cycle, with no idle cycle, even on a region change or read-to-write turnaround.
- R12: A strobe is issued only in the cycle after ack_i was sampled high; while ack_i is low a taken request waits with the bus idle.
- R13: busy_o is high exactly in idle, ack-wait and hold cycles, and is never high together with a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present; taken in a cycle where busy_o is low |
| req_addr_i | input | AW | Request word address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| bank_size_lg_i | input | $clog2(AW) | Base-2 logarithm of the bank size in words |
| region_async_i | input | NB+1 | Per region async mode bit; bit NB is the unbanked region |
| region_wcode_i | input | 3*(NB+1) | Per region 3-bit waitstate code; region r at bits 3r+2..3r |
| ack_i | input | 1 | Bus acknowledge, sampled at each rising edge |
| bank_sel_n_o | output | NB | Active-low bank selects, bit n = bank n |
| rd_strobe_o | output | 1 | Read strobe |
| wr_strobe_o | output | 1 | Write strobe |
| bus_addr_o | output | AW | Bus address, zero when the bus is idle |
| busy_o | output | 1 | Stall for the requester |

## Verification
A request taken at a rising edge with ack high shows its strobe after that same edge. A second request taken during that strobe cycle shows its strobe one cycle later, or two cycles later when an idle or a hold cycle comes between. The cycle after the second strobe may hold a hold cycle, and three cycles after it the bus must be idle. The bench drives inputs and samples outputs on falling edges, one cycle per step, so every check lands in the cycle that the counted register stages predict. It sweeps boundary and interior addresses of every region, all four direction pairs, two bank sizes and two region-mode sets, and computes the region, the select pattern and whether an idle or a hold cycle is due arithmetically.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
    localparam int WCODE_W = 3;
    localparam logic [WCODE_W-1:0] HOLD_MIN_CODE = 3'b010;

    typedef enum logic [2:0] {
        ST_FREE,
        ST_WAIT,
        ST_GAP,
        ST_XFER,
        ST_HOLD
    } ebs_state_e;
endpackage

// File: rtl/ebs_region_decode.sv
module ebs_region_decode #(
    parameter int AW = 32,
    parameter int NB = 4,
    parameter logic [AW-1:0] BASE = 'h0080_0000,
    parameter int LW = 5,
    parameter int RW = 3
) (
    input  logic [AW-1:0] addr_i,
    input  logic [LW-1:0] size_lg_i,
    output logic [RW-1:0] rgn_o
);
    // extra headroom so n*size never wraps for legal sizes
    localparam int EW = AW + 3;

    logic [EW-1:0] size_w;
    logic [EW-1:0] addr_w;
    logic [NB-1:0] hit;

    assign size_w = EW'(1) << size_lg_i;
    assign addr_w = EW'(addr_i);

    for (genvar n = 0; n < NB; n++) begin : g_bank
        logic [EW-1:0] lo;
        logic [EW-1:0] hi;
        assign lo     = EW'(BASE) + EW'(n) * size_w;
        assign hi     = lo + size_w;
        assign hit[n] = (addr_w >= lo) && (addr_w < hi);
    end

    // region NB means unbanked (below the base or past the last bank)
    always_comb begin
        rgn_o = RW'(NB);
        for (int k = NB - 1; k >= 0; k--) begin
            if (hit[k]) rgn_o = RW'(k);
        end
    end
endmodule

// File: rtl/ebs_spacing_rules.sv
module ebs_spacing_rules
    import ebs_pkg::*;
#(
    parameter int NB = 4,
    parameter int RW = 3
) (
    input  logic [RW-1:0]              cur_rgn_i,
    input  logic                       cur_wr_i,
    input  logic [RW-1:0]              new_rgn_i,
    input  logic                       new_wr_i,
    input  logic [NB:0]                region_async_i,
    input  logic [(NB+1)*WCODE_W-1:0]  region_wcode_i,
    output logic                       gap_needed_o,
    output logic                       hold_due_o
);
    localparam int NS = 1 << RW;

    logic               slot_async [NS];
    logic [WCODE_W-1:0] slot_code  [NS];

    for (genvar s = 0; s < NS; s++) begin : g_slot
        if (s <= NB) begin : g_used
            assign slot_async[s] = region_async_i[s];
            assign slot_code[s]  = region_wcode_i[s*WCODE_W +: WCODE_W];
        end else begin : g_spare
            assign slot_async[s] = 1'b0;
            assign slot_code[s]  = '0;
        end
    end

    assign hold_due_o   = slot_async[cur_rgn_i] && (slot_code[cur_rgn_i] >= HOLD_MIN_CODE);
    assign gap_needed_o = (cur_rgn_i != new_rgn_i) || (!cur_wr_i && new_wr_i);
endmodule

// File: rtl/ext_bank_sequencer.sv
module ext_bank_sequencer
    import ebs_pkg::*;
#(
    parameter int AW = 32,
    parameter int NB = 4,
    parameter logic [AW-1:0] BASE = 'h0080_0000,
    localparam int LW = $clog2(AW)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid_i,
    input  logic [AW-1:0]             req_addr_i,
    input  logic                      req_write_i,
    input  logic [LW-1:0]             bank_size_lg_i,
    input  logic [NB:0]               region_async_i,
    input  logic [(NB+1)*WCODE_W-1:0] region_wcode_i,
    input  logic                      ack_i,
    output logic [NB-1:0]             bank_sel_n_o,
    output logic                      rd_strobe_o,
    output logic                      wr_strobe_o,
    output logic [AW-1:0]             bus_addr_o,
    output logic                      busy_o
);
    localparam int RW = $clog2(NB + 1);

    typedef struct packed {
        ebs_state_e     st;
        logic [AW-1:0]  c_addr;
        logic [RW-1:0]  c_rgn;
        logic           c_wr;
        logic           p_vld;
        logic [AW-1:0]  p_addr;
        logic [RW-1:0]  p_rgn;
        logic           p_wr;
    } seq_s;

    seq_s          s_d, s_q;
    logic [RW-1:0] req_rgn;
    logic          gap_needed;
    logic          hold_due;
    logic          accept;
    logic          on_bus;

    ebs_region_decode #(
        .AW(AW), .NB(NB), .BASE(BASE), .LW(LW), .RW(RW)
    ) u_decode (
        .addr_i    (req_addr_i),
        .size_lg_i (bank_size_lg_i),
        .rgn_o     (req_rgn)
    );

    ebs_spacing_rules #(
        .NB(NB), .RW(RW)
    ) u_rules (
        .cur_rgn_i      (s_q.c_rgn),
        .cur_wr_i       (s_q.c_wr),
        .new_rgn_i      (req_rgn),
        .new_wr_i       (req_write_i),
        .region_async_i (region_async_i),
        .region_wcode_i (region_wcode_i),
        .gap_needed_o   (gap_needed),
        .hold_due_o     (hold_due)
    );

    assign busy_o = (s_q.st == ST_GAP) || (s_q.st == ST_WAIT) || (s_q.st == ST_HOLD);
    assign accept = req_valid_i && !busy_o;
    assign on_bus = (s_q.st == ST_XFER) || (s_q.st == ST_HOLD);

    assign rd_strobe_o  = (s_q.st == ST_XFER) && !s_q.c_wr;
    assign wr_strobe_o  = (s_q.st == ST_XFER) && s_q.c_wr;
    assign bus_addr_o   = on_bus ? s_q.c_addr : '0;
    assign bank_sel_n_o = (on_bus && (s_q.c_rgn < RW'(NB))) ? ~(NB'(1) << s_q.c_rgn) : '1;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_FREE: begin
                if (accept) begin
                    s_d.c_addr = req_addr_i;
                    s_d.c_rgn  = req_rgn;
                    s_d.c_wr   = req_write_i;
                    s_d.st     = ack_i ? ST_XFER : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (ack_i) s_d.st = ST_XFER;
            end
            ST_GAP: begin
                s_d.st = ack_i ? ST_XFER : ST_WAIT;
            end
            ST_XFER: begin
                if (hold_due) begin
                    // hold replaces any idle cycle; queue the next request
                    s_d.st = ST_HOLD;
                    if (accept) begin
                        s_d.p_vld  = 1'b1;
                        s_d.p_addr = req_addr_i;
                        s_d.p_rgn  = req_rgn;
                        s_d.p_wr   = req_write_i;
                    end
                end else if (accept) begin
                    s_d.c_addr = req_addr_i;
                    s_d.c_rgn  = req_rgn;
                    s_d.c_wr   = req_write_i;
                    s_d.st     = gap_needed ? ST_GAP : (ack_i ? ST_XFER : ST_WAIT);
                end else begin
                    s_d.st = ST_FREE;
                end
            end
            ST_HOLD: begin
                if (s_q.p_vld) begin
                    s_d.c_addr = s_q.p_addr;
                    s_d.c_rgn  = s_q.p_rgn;
                    s_d.c_wr   = s_q.p_wr;
                    s_d.p_vld  = 1'b0;
                    s_d.st     = ack_i ? ST_XFER : ST_WAIT;
                end else begin
                    s_d.st = ST_FREE;
                end
            end
            default: s_d.st = ST_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_FREE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/ebs_sequencer_chk.sv
module ebs_sequencer_chk #(
    parameter int AW = 32,
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack_i,
    input logic [NB-1:0] bank_sel_n_o,
    input logic          rd_strobe_o,
    input logic          wr_strobe_o,
    input logic [AW-1:0] bus_addr_o,
    input logic          busy_o
);
    logic strobe;
    assign strobe = rd_strobe_o || wr_strobe_o;

    p_one_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bank_sel_n_o));

    p_idle_bus_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !$past(strobe)) |-> ((&bank_sel_n_o) && (bus_addr_o == '0)));

    p_no_read_to_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe_o |=> !wr_strobe_o);

    p_same_region_adjacent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && $past(strobe)) |-> $stable(bank_sel_n_o));

    p_hold_keeps_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !(&bank_sel_n_o)) |-> ($past(strobe) && $stable(bank_sel_n_o) && $stable(bus_addr_o)));

    p_launch_after_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $past(ack_i));

    p_busy_no_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !strobe);
endmodule

bind ext_bank_sequencer ebs_sequencer_chk #(
    .AW(AW), .NB(NB)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_i        (ack_i),
    .bank_sel_n_o (bank_sel_n_o),
    .rd_strobe_o  (rd_strobe_o),
    .wr_strobe_o  (wr_strobe_o),
    .bus_addr_o   (bus_addr_o),
    .busy_o       (busy_o)
);

// File: tb/ext_bank_sequencer_tb.sv
module ext_bank_sequencer_tb;
    localparam int          CLK_P = 10;
    localparam int          AW    = 32;
    localparam int          NB    = 4;
    localparam logic [31:0] BASE  = 32'h0080_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [31:0]   req_addr = '0;
    logic          req_write = 1'b0;
    logic [4:0]    size_lg = 5'd4;
    logic [NB:0]   rg_async = '0;
    logic [14:0]   rg_wcode = '0;
    logic          ack = 1'b1;
    logic [NB-1:0] sel_n;
    logic          rd, wr, busy;
    logic [31:0]   baddr;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    ext_bank_sequencer u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid_i    (req_valid),
        .req_addr_i     (req_addr),
        .req_write_i    (req_write),
        .bank_size_lg_i (size_lg),
        .region_async_i (rg_async),
        .region_wcode_i (rg_wcode),
        .ack_i          (ack),
        .bank_sel_n_o   (sel_n),
        .rd_strobe_o    (rd),
        .wr_strobe_o    (wr),
        .bus_addr_o     (baddr),
        .busy_o         (busy)
    );

    task automatic chk(longint act, longint exp, string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_rgn(logic [31:0] a, int lg);
        longint off;
        if (a < BASE) return NB;
        off = (longint'(a) - longint'(BASE)) >>> lg;
        return (off < NB) ? int'(off) : NB;
    endfunction

    function automatic logic [NB-1:0] exp_sel(int r);
        return (r < NB) ? ~(4'b0001 << r) : 4'b1111;
    endfunction

    function automatic bit hold_of(int r);
        return rg_async[r] && (rg_wcode[r*3 +: 3] >= 3'd2);
    endfunction

    // observed cycle kind: 2 strobe, 1 hold (address kept), 0 idle
    function automatic int obs_kind();
        if (rd || wr) return 2;
        if (baddr != 0) return 1;
        return 0;
    endfunction

    function automatic logic [31:0] pick_addr(int i, int lg);
        longint sz;
        sz = longint'(1) << lg;
        case (i)
            0: return BASE - 1;
            1: return BASE;
            2: return 32'(longint'(BASE) + sz - 1);
            3: return 32'(longint'(BASE) + sz);
            4: return 32'(longint'(BASE) + 2 * sz + 3);
            5: return 32'(longint'(BASE) + 4 * sz - 1);
            6: return 32'(longint'(BASE) + 4 * sz);
            default: return 32'(longint'(BASE) + 4 * sz + 100);
        endcase
    endfunction

    task automatic chk_strobe(logic [31:0] a, bit w, string tag);
        int r;
        r = exp_rgn(a, int'(size_lg));
        chk(obs_kind(), 2, tag);
        chk(sel_n, exp_sel(r), (r < NB) ? "R2 select" : "R3 unbanked select");
        chk({rd, wr}, {!w, w}, "R5 strobe type");
        chk(baddr, a, "R5 address");
        chk(busy, 0, "R13 busy in strobe");
    endtask

    task automatic chk_idle(string tag);
        chk(sel_n, 4'hF, tag);
        chk({rd, wr}, 0, tag);
        chk(baddr, 0, tag);
    endtask

    task automatic run_pair(logic [31:0] a1, bit w1, logic [31:0] a2, bit w2);
        int  r1, r2;
        bit  h1, g;
        r1 = exp_rgn(a1, int'(size_lg));
        r2 = exp_rgn(a2, int'(size_lg));
        h1 = hold_of(r1);
        g  = (r1 != r2) || (!w1 && w2);
        req_valid = 1'b1; req_addr = a1; req_write = w1;
        tick();
        chk_strobe(a1, w1, "R5 first strobe timing");
        req_addr = a2; req_write = w2;
        tick();
        req_valid = 1'b0;
        if (!h1) chk(obs_kind() == 1, 0, "R10 no hold cycle");
        if (h1) begin
            chk(obs_kind(), 1, "R9 hold cycle kind");
            chk(sel_n, exp_sel(r1), "R9 hold select kept");
            chk(baddr, a1, "R9 hold address kept");
            chk(busy, 1, "R13 busy in hold");
            tick();
            chk_strobe(a2, w2, g ? "R11 no idle after hold" : "R9 strobe after hold");
        end else if (g) begin
            chk(obs_kind(), 0, (r1 == r2) ? "R6 turnaround idle" : "R7 region change idle");
            chk_idle("R4 idle cycle bus");
            chk(busy, 1, "R13 busy in idle");
            tick();
            chk_strobe(a2, w2, (r1 == r2) ? "R6 strobe after idle" : "R7 strobe after idle");
        end else begin
            chk_strobe(a2, w2, "R8 back-to-back strobe");
        end
        tick(); tick(); tick();
        chk_idle("R4 drained bus");
        chk(busy, 0, "R13 busy after drain");
    endtask

    initial begin
        @(negedge clk);
        chk_idle("R1 reset outputs");
        chk(busy, 0, "R1 reset busy");
        tick();
        rst_n = 1'b1;
        tick();
        chk_idle("R1 after reset outputs");
        chk(busy, 0, "R1 after reset busy");

        for (int cf = 0; cf < 2; cf++) begin
            if (cf == 0) begin
                rg_async = 5'b00000;
                rg_wcode = {5{3'b111}};
            end else begin
                rg_async = 5'b10101;
                rg_wcode = {3'b101, 3'b000, 3'b001, 3'b111, 3'b010};
            end
            for (int li = 0; li < 2; li++) begin
                size_lg = (li == 0) ? 5'd4 : 5'd6;
                for (int ai = 0; ai < 8; ai++) begin
                    for (int bi = 0; bi < 8; bi++) begin
                        for (int wi = 0; wi < 4; wi++) begin
                            run_pair(pick_addr(ai, int'(size_lg)), wi[1],
                                     pick_addr(bi, int'(size_lg)), wi[0]);
                        end
                    end
                end
            end
        end

        // ack gating: request taken while ack is low waits with the bus idle
        rg_async = '0;
        size_lg  = 5'd4;
        ack = 1'b0;
        req_valid = 1'b1; req_addr = BASE + 32'd1; req_write = 1'b0;
        tick();
        req_valid = 1'b0;
        chk(obs_kind(), 0, "R12 no strobe without ack");
        chk(busy, 1, "R13 busy while waiting for ack");
        tick();
        chk(obs_kind(), 0, "R12 still waiting");
        chk_idle("R4 bus idle while waiting");
        ack = 1'b1;
        tick();
        chk_strobe(BASE + 32'd1, 1'b0, "R12 strobe after ack high");
        tick();
        chk_idle("R4 idle after ack test");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R13 watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule